// File: doc/BRIEF.md
# Serial-Bus Wiper Position Register

This block is a two-wire serial bus slave (I2C protocol) that owns one 7-bit volatile code for a digitally controlled resistor ladder. The code goes straight out to the analog switch network. 00h puts the wiper closest to the low end of the ladder and 7Fh puts it closest to the high end, and the position moves monotonically between them. The block samples SCL and SDA with the system clock through two-flop synchronizers, so the system clock must run well above the bus bit rate. It pulls SDA low through an active-high enable and never drives it high.

A host changes the code with a short transaction: START, the identifier with a write flag, register address 00h, one data byte, then STOP. The new code takes effect when SCL falls after the last data bit. The host reads the code by sending the identifier and address as a write, then a repeated START and the identifier with the read flag. The slave then sends the code for as long as the host acknowledges each byte. The slave does not acknowledge a wrong identifier, a wrong address or any surplus byte, and it ignores the rest of that transaction. A START or STOP seen at any point drops whatever was in progress.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the wiper code is 40h and the SDA pull-down enable is low.
- R2: A complete write transaction (identifier byte 5Ch, address 00h, data byte D, STOP) sets the wiper code to D[6:0]. D[7] is discarded, and the code is presented unchanged on the wiper output.
- R3: The written code does not appear while SCL is high during the data LSB. It appears within a few system clocks after that SCL falling edge.
- R4: The slave acknowledges by pulling SDA low during the ninth SCL clock. It does so for an identifier byte whose upper seven bits are 0101110, for address byte 00h, and for the first data byte of a write. Bit 0 of the identifier selects the direction: 0 for write, 1 for read.
- R5: An identifier with any other upper seven bits gets no acknowledge. The rest of the transaction is ignored and the wiper code is unchanged.
- R6: A valid identifier followed by an address other than 00h gets no acknowledge on the address. The data byte that follows is neither acknowledged nor stored.
- R7: In a read (write identifier 5Ch, address 00h, repeated START, read identifier 5Dh), all three bytes are acknowledged. The slave then sends {0, code} MSB first and sends it again after each byte the host acknowledges.
- R8: A host NACK after a read byte makes the slave release SDA. The slave then stays silent until the next START.
- R9: A read identifier (5Dh) that follows START without an acknowledged address earlier in the same transaction gets no acknowledge.
- R10: A START or STOP seen in any state abandons the byte in progress and releases SDA. A partly received data byte never reaches the wiper code.
- R11: Before the first START, SCL and SDA activity never causes SDA to be pulled low.
- R12: The SDA pull-down enable asserts only while SCL is low.
- R13: A second data byte in one write transaction gets no acknowledge and does not change the code stored by the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| wiper_o | output | 7 | Current wiper code to the resistor switch network |

## Verification
The main write path is driven with codes at both ends of the range, with a code whose bit 7 is set, and with alternating-bit patterns. These show whether all seven bits land in their places and whether bit 7 is dropped. The same path is then run with a wrong identifier, a wrong address and a surplus data byte. Each of these changes only the acknowledge pattern, which separates the identifier check, the address check and the byte-count check from one another. Reads are made with one host acknowledge followed by a NACK, and a read without an address phase is also tried, so that repeated transmission, release on NACK and the address precondition are each observed. Directed sequences cover the commit edge, aborts by STOP and by START partway through a byte, and bus activity before any START.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RECV,
    LS_SLV_ACK,
    LS_SEND,
    LS_HOST_ACK,
    LS_SKIP
  } link_state_t;

  typedef enum logic [1:0] {
    BK_IDENT,
    BK_REGSEL,
    BK_VALUE
  } byte_kind_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_i;
            sda_chain[g] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int unsigned         WIPER_W    = 7,
  parameter logic [WIPER_W-1:0]  RESET_CODE = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [WIPER_W-1:0] load_data,
  output logic [WIPER_W-1:0] code_o
);

  logic [WIPER_W-1:0] code_q;
  logic [WIPER_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (load_en) code_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RESET_CODE;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/i2c_wiper_fsm.sv
module i2c_wiper_fsm
  import pot_i2c_pkg::*;
#(
  parameter int unsigned        WIPER_W  = 7,
  parameter logic [6:0]         DEV_ID   = 7'h2E,
  parameter logic [BYTE_W-1:0]  REG_ADDR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [WIPER_W-1:0] wiper_q,
  output logic               sda_pull,
  output logic               wr_en,
  output logic [WIPER_W-1:0] wr_data
);

  localparam int unsigned PAD_W = BYTE_W - WIPER_W;
  localparam logic [BIT_CNT_W-1:0] LAST_RX = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_TX = BIT_CNT_W'(BYTE_W - 1);

  link_state_t           state_q, state_d;
  byte_kind_t            kind_q, kind_d;
  logic [BIT_CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0]     shr_q, shr_d;
  logic                  pull_q, pull_d;
  logic                  addr_ok_q, addr_ok_d;
  logic                  rd_q, rd_d;
  logic [BYTE_W-1:0]     tx_byte;

  assign tx_byte = {{PAD_W{1'b0}}, wiper_q};
  assign wr_data = shr_q[WIPER_W-1:0];

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    cnt_d     = cnt_q;
    shr_d     = shr_q;
    pull_d    = pull_q;
    addr_ok_d = addr_ok_q;
    rd_d      = rd_q;
    wr_en     = 1'b0;
    if (start_det) begin
      state_d = LS_RECV;
      kind_d  = BK_IDENT;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d   = LS_IDLE;
      pull_d    = 1'b0;
      addr_ok_d = 1'b0;
    end else begin
      unique case (state_q)
        LS_RECV: begin
          if (scl_rise) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_RX) begin
            cnt_d   = '0;
            state_d = LS_SKIP;
            unique case (kind_q)
              BK_IDENT: begin
                if (shr_q[BYTE_W-1:1] == DEV_ID && (!shr_q[0] || addr_ok_q)) begin
                  state_d = LS_SLV_ACK;
                  rd_d    = shr_q[0];
                end
              end
              BK_REGSEL: begin
                if (shr_q == REG_ADDR) begin
                  state_d   = LS_SLV_ACK;
                  addr_ok_d = 1'b1;
                end
              end
              default: begin
                wr_en   = 1'b1;
                state_d = LS_SLV_ACK;
              end
            endcase
            pull_d = (state_d == LS_SLV_ACK);
            if (state_d == LS_SKIP) addr_ok_d = 1'b0;
          end
        end
        LS_SLV_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            unique case (kind_q)
              BK_IDENT: begin
                if (rd_q) begin
                  state_d = LS_SEND;
                  shr_d   = tx_byte;
                  pull_d  = ~tx_byte[BYTE_W-1];
                end else begin
                  state_d = LS_RECV;
                  kind_d  = BK_REGSEL;
                end
              end
              BK_REGSEL: begin
                state_d = LS_RECV;
                kind_d  = BK_VALUE;
              end
              default: state_d = LS_SKIP;
            endcase
          end
        end
        LS_SEND: begin
          if (scl_fall) begin
            if (cnt_q == LAST_TX) begin
              pull_d  = 1'b0;
              cnt_d   = '0;
              state_d = LS_HOST_ACK;
            end else begin
              shr_d  = {shr_q[BYTE_W-2:0], 1'b0};
              pull_d = ~shr_q[BYTE_W-2];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        LS_HOST_ACK: begin
          if (scl_rise && sda_s) begin
            state_d = LS_IDLE;
          end else if (scl_fall) begin
            state_d = LS_SEND;
            shr_d   = tx_byte;
            pull_d  = ~tx_byte[BYTE_W-1];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LS_IDLE;
      kind_q    <= BK_IDENT;
      cnt_q     <= '0;
      shr_q     <= '0;
      pull_q    <= 1'b0;
      addr_ok_q <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      shr_q     <= shr_d;
      pull_q    <= pull_d;
      addr_ok_q <= addr_ok_d;
      rd_q      <= rd_d;
    end
  end

  assign sda_pull = pull_q;

endmodule

// File: rtl/i2c_wiper_ctrl.sv
module i2c_wiper_ctrl
  import pot_i2c_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter int unsigned        WIPER_W     = 7,
  parameter logic [6:0]         DEV_ID      = 7'h2E,
  parameter logic [BYTE_W-1:0]  REG_ADDR    = 8'h00,
  parameter logic [WIPER_W-1:0] RESET_CODE  = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper_o
);

  logic               rst_meta;
  logic               rst_ns;
  logic               scl_s, sda_s;
  logic               scl_rise, scl_fall;
  logic               start_det, stop_det;
  logic               wr_en;
  logic [WIPER_W-1:0] wr_data;
  logic [WIPER_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wiper_fsm #(
    .WIPER_W  (WIPER_W),
    .DEV_ID   (DEV_ID),
    .REG_ADDR (REG_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wiper_q   (code),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  wiper_store #(
    .WIPER_W    (WIPER_W),
    .RESET_CODE (RESET_CODE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load_en   (wr_en),
    .load_data (wr_data),
    .code_o    (code)
  );

  assign wiper_o = code;

endmodule

// File: rtl/i2c_wiper_ctrl_chk.sv
module i2c_wiper_ctrl_chk #(
  parameter int unsigned        WIPER_W    = 7,
  parameter logic [WIPER_W-1:0] RESET_CODE = 7'h40
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               scl_s,
  input logic               scl_fall,
  input logic               start_det,
  input logic               stop_det,
  input logic               sda_pull_o,
  input logic [WIPER_W-1:0] wiper_o
);

  always @(negedge clk) begin
    if (!rst_ns) begin
      AST_RESET_MIDSCALE: assert (wiper_o == RESET_CODE && !sda_pull_o); // R1
    end
  end

  AST_CODE_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(wiper_o) |-> $past(scl_fall)); // R3

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_pull_o) |-> !$past(scl_s)); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_ns)
    stop_det |=> !sda_pull_o); // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_ns)
    start_det |=> !sda_pull_o); // R10

endmodule

bind i2c_wiper_ctrl i2c_wiper_ctrl_chk #(
  .WIPER_W    (WIPER_W),
  .RESET_CODE (RESET_CODE)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .scl_s      (scl_s),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_pull_o (sda_pull_o),
  .wiper_o    (wiper_o)
);

// File: tb/i2c_wiper_ctrl_tb.sv
module i2c_wiper_ctrl_tb;

  localparam int Q = 10;
  localparam int NV = 9;
  // {ident, addr, data, 5'b0 + acks[id,addr,data], 1'b0 + expected code}
  localparam logic [39:0] VEC [NV] = '{
    40'h5C_00_7F_07_7F,
    40'h5C_00_00_07_00,
    40'h5C_00_A5_07_25,
    40'h5C_01_33_04_25,
    40'h5E_00_11_00_25,
    40'h5C_00_55_07_55,
    40'h4C_00_12_00_55,
    40'h5C_80_12_04_55,
    40'h5C_00_2A_07_2A
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_pull;
  logic [6:0] wiper;
  logic       sda_line;
  int         errs = 0;
  int         checks = 0;
  int         pull_cnt = 0;
  bit         done = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_wiper_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .wiper_o    (wiper)
  );

  always @(posedge clk) if (sda_pull) pull_cnt <= pull_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic get_ack(output logic ack);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); ack = ~sda_line; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_scl = 1'b1; w(Q); d[i] = sda_line; w(Q); m_scl = 1'b0;
    end
    w(Q);
    put_bit(~host_ack);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d0, d1;
    int pc;
    w(4);
    chk("R1 code during reset", 32'(wiper), 32'h40);
    rst_n = 1'b1;
    w(6);
    chk("R1 code after reset", 32'(wiper), 32'h40);
    chk("R1 pull after reset", 32'(sda_pull), 32'h0);

    // R11: clocked activity with no START, identifier pattern plus ack slot
    m_scl = 1'b0; w(Q);
    pc = pull_cnt;
    for (int i = 7; i >= 0; i--) put_bit(8'h5C >> i);
    get_ack(a0);
    chk("R11 no ack before START", 32'(a0), 32'h0);
    chk("R11 no pull before START", 32'(pull_cnt - pc), 32'h0);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(2*Q);

    // R2 R4 R5 R6: vector walk
    for (int v = 0; v < NV; v++) begin
      bus_start();
      put_byte(VEC[v][39:32], a0);
      put_byte(VEC[v][31:24], a1);
      put_byte(VEC[v][23:16], a2);
      bus_stop();
      w(5);
      chk($sformatf("R4/R5/R6 acks vec%0d", v), 32'({a0, a1, a2}), 32'(VEC[v][10:8]));
      chk($sformatf("R2 code vec%0d", v), 32'(wiper), 32'(VEC[v][6:0]));
    end

    // R7 R8: read with one host ack then NACK
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1);
    bus_start();
    put_byte(8'h5D, a2);
    get_byte(1'b1, d0);
    get_byte(1'b0, d1);
    w(2);
    chk("R8 released after host NACK", 32'(sda_pull), 32'h0);
    bus_stop();
    chk("R7 read header acks", 32'({a0, a1, a2}), 32'h7);
    chk("R7 first read byte", 32'(d0), 32'h2A);
    chk("R7 repeated read byte", 32'(d1), 32'h2A);

    // R9: read identifier without an address phase
    bus_start();
    put_byte(8'h5D, a0);
    bus_stop();
    chk("R9 read without address nacked", 32'(a0), 32'h0);

    // R3: commit on the SCL fall of the data LSB
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1);
    for (int i = 7; i >= 1; i--) put_bit(8'h13 >> i);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(2*Q);
    chk("R3 code held while LSB high", 32'(wiper), 32'h2A);
    m_scl = 1'b0; w(Q);
    chk("R3 code after LSB fall", 32'(wiper), 32'h13);
    get_ack(a2);
    bus_stop();
    chk("R4 data ack", 32'(a2), 32'h1);

    // R13: surplus data byte
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1); put_byte(8'h11, a2); put_byte(8'h22, a3);
    bus_stop(); w(5);
    chk("R13 surplus byte nacked", 32'(a3), 32'h0);
    chk("R13 code keeps first byte", 32'(wiper), 32'h11);

    // R10: STOP mid data byte
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1);
    for (int i = 7; i >= 4; i--) put_bit(8'h7F >> i);
    bus_stop(); w(5);
    chk("R10 STOP discards partial byte", 32'(wiper), 32'h11);
    chk("R10 STOP releases SDA", 32'(sda_pull), 32'h0);

    // R10: repeated START mid data byte, then a full write
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1);
    for (int i = 7; i >= 5; i--) put_bit(8'h00 >> i);
    chk("R10 code unchanged before restart", 32'(wiper), 32'h11);
    bus_start();
    put_byte(8'h5C, a0); put_byte(8'h00, a1); put_byte(8'h33, a2);
    bus_stop(); w(5);
    chk("R10 acks after restart", 32'({a0, a1, a2}), 32'h7);
    chk("R10 write after restart", 32'(wiper), 32'h33);

    // R1: reset during operation
    rst_n = 1'b0; w(3);
    chk("R1 code back to midscale", 32'(wiper), 32'h40);
    rst_n = 1'b1; w(6);
    chk("R1 pull low after reset", 32'(sda_pull), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule